// File: doc/BRIEF.md
# Clock-Enable Tick Divider

This block turns a stream of enabled clock cycles into a periodic one-cycle tick, so that slower logic downstream can keep time without a second clock. A single count register advances only on cycles where the count enable is high. The tick is a combinational decode of that register, gated by the enable, so it marks the enabled cycle on which the register sits at its terminal value.

The divide method is chosen at run time by a two-bit mode input. In free-run mode the register is a plain binary up-counter that wraps from all ones to zero, which gives a period of 2^CNT_W. In modulo mode it counts up from zero and clears after it reaches the `limit` input, which gives a period of `limit`+1. In reload mode it counts down and reloads `limit` after it reaches zero, which also gives a period of `limit`+1. The last two modes give periods that are not powers of two. For example, a limit of 8 divides by 9 and a limit of 59 divides by 60.

Top module: `tick_divider`

## Requirements
- R1: In free-run mode (mode code 0, and the spare code 3), each enabled cycle adds one to `count`, and the count goes from all ones back to zero.
- R2: In free-run mode `tick` is high on an enabled cycle whose `count` is all ones, so ticks are 2^CNT_W enabled cycles apart (256 for CNT_W = 8).
- R3: In modulo mode (mode code 1), `count` runs 0, 1, …, `limit` and returns to 0 on the enabled cycle after `limit`. `tick` is high on an enabled cycle whose `count` equals `limit`, so ticks are `limit`+1 enabled cycles apart.
- R4: In modulo mode, a `count` above `limit` (left over from another mode) becomes 0 on the next enabled cycle, and that cycle gives no tick.
- R5: In reload mode (mode code 2), each enabled cycle takes one from `count`, and the enabled cycle after zero loads `limit`. `tick` is high on an enabled cycle whose `count` is zero, so ticks are `limit`+1 enabled cycles apart.
- R6: While `en` is low, `count` holds its value and `tick` stays low.
- R7: A clock edge with `rst` high sets `count` to 0 in modes 0, 1 and 3, and to `limit` in mode 2. `tick` is low on any cycle where `rst` is high.
- R8: With `limit` = 0, modes 1 and 2 both tick on every enabled cycle and `count` stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| mode | input | 2 | 0 free-run, 1 modulo, 2 reload, 3 free-run |
| limit | input | CNT_W | Terminal value for modulo mode, reload value for reload mode |
| tick | output | 1 | One-cycle pulse at the terminal count |
| count | output | CNT_W | Current count |

## Verification
The case that is hardest to reach from the ports is a modulo-mode count that is already above `limit`. In normal operation the register never gets past `limit`. To get there, the stimulus runs in free-run mode until the count is near 100, then switches to modulo mode with a limit of 20 while counting continues. The scoreboard then expects a clear with no tick. The spacing checks for periods of 9, 60 and 256 cover several full periods each, and a burst with the enable toggling shows that only enabled cycles are counted.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;
   typedef enum logic [1:0] {
      TD_FREE   = 2'd0,
      TD_MODULO = 2'd1,
      TD_RELOAD = 2'd2,
      TD_SPARE  = 2'd3
   } td_mode_e;
endpackage

// File: rtl/tdiv_step.sv
// Half-adder incrementer and half-subtractor decrementer built as ripple chains.
module tdiv_step #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] val,
   output logic [CNT_W-1:0] inc,
   output logic [CNT_W-1:0] dec
);
   logic [CNT_W-1:0] carry;
   logic [CNT_W-1:0] borrow;

   assign carry[0]  = 1'b1;
   assign borrow[0] = 1'b1;

   for (genvar i = 0; i < CNT_W; i++) begin : g_bit
      assign inc[i] = val[i] ^ carry[i];
      assign dec[i] = val[i] ^ borrow[i];
   end

   for (genvar i = 0; i < CNT_W - 1; i++) begin : g_chain
      assign carry[i+1]  = val[i] & carry[i];
      assign borrow[i+1] = ~val[i] & borrow[i];
   end
endmodule

// File: rtl/tdiv_term.sv
// Terminal-value detectors shared by every mode.
module tdiv_term #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] val,
   input  logic [CNT_W-1:0] limit,
   output logic             all_ones,
   output logic             all_zero,
   output logic             at_limit,
   output logic             over_limit
);
   assign all_ones   = &val;
   assign all_zero   = ~|val;
   assign at_limit   = (val == limit);
   assign over_limit = (val > limit);
endmodule

// File: rtl/tdiv_sel.sv
// Chooses the terminal flag, the next value and the reset value for each mode.
module tdiv_sel
   import tick_div_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  td_mode_e         mode,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] inc,
   input  logic [CNT_W-1:0] dec,
   input  logic             all_ones,
   input  logic             all_zero,
   input  logic             at_limit,
   input  logic             over_limit,
   output logic             term_hit,
   output logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] rst_val
);
   always_comb begin
      term_hit = all_ones;
      nxt      = inc;
      rst_val  = '0;
      unique case (mode)
         TD_MODULO: begin
            term_hit = at_limit;
            nxt      = (at_limit | over_limit) ? '0 : inc;
         end
         TD_RELOAD: begin
            term_hit = all_zero;
            nxt      = all_zero ? limit : dec;
            rst_val  = limit;
         end
         default: begin
            term_hit = all_ones;
            nxt      = inc;
         end
      endcase
   end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
   import tick_div_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] limit,
   output logic             tick,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("tick_divider: CNT_W must be at least 2");
   end

   td_mode_e         m;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] inc, dec, nxt, rst_val;
   logic             all_ones, all_zero, at_limit, over_limit, term_hit;

   assign m = td_mode_e'(mode);

   tdiv_step #(.CNT_W(CNT_W)) u_step (
      .val(cnt_q), .inc(inc), .dec(dec)
   );

   tdiv_term #(.CNT_W(CNT_W)) u_term (
      .val(cnt_q), .limit(limit), .all_ones(all_ones), .all_zero(all_zero),
      .at_limit(at_limit), .over_limit(over_limit)
   );

   tdiv_sel #(.CNT_W(CNT_W)) u_sel (
      .mode(m), .limit(limit), .inc(inc), .dec(dec), .all_ones(all_ones),
      .all_zero(all_zero), .at_limit(at_limit), .over_limit(over_limit),
      .term_hit(term_hit), .nxt(nxt), .rst_val(rst_val)
   );

   always_ff @(posedge clk) begin
      if (rst)     cnt_q <= rst_val;
      else if (en) cnt_q <= nxt;
   end

   assign tick  = en & ~rst & term_hit;
   assign count = cnt_q;

   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && (m == TD_FREE || m == TD_SPARE) && count == '1) |=> count == '0); // R1
   AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
      (en && (m == TD_FREE || m == TD_SPARE) && count != '1) |=> count == $past(count) + ONE); // R1
   AST_MOD_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (en && m == TD_MODULO && count >= limit) |=> count == '0); // R4
   AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
      (en && m == TD_RELOAD && count == '0) |=> count == $past(limit)); // R5
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(count)); // R6
endmodule

// File: tb/tick_divider_test.sv
`timescale 1ns/100ps
module tick_divider_test;
   typedef struct {
      logic       tk;
      logic [7:0] cn;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [7:0] limit = 8'd0;
   logic       tick;
   logic [7:0] count;

   exp_t       sb[$];
   logic [7:0] m_cnt = 8'd0;
   int         n_chk = 0;
   int         n_bad = 0;
   int         exp_period = 0;
   string      sp_req = "R2";
   bit         have_prev = 1'b0;
   int         prev_idx = 0;
   int         en_idx = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   tick_divider #(.CNT_W(8)) uut (
      .clk(clk), .rst(rst), .en(en), .mode(mode), .limit(limit),
      .tick(tick), .count(count)
   );

   function automatic logic [7:0] mnext(logic [1:0] md, logic [7:0] lim, logic [7:0] c);
      case (md)
         2'd1:    return (c >= lim) ? 8'd0 : c + 8'd1;
         2'd2:    return (c == 8'd0) ? lim : c - 8'd1;
         default: return c + 8'd1;
      endcase
   endfunction

   function automatic logic mtick(logic r, logic e, logic [1:0] md, logic [7:0] lim, logic [7:0] c);
      if (r || !e) return 1'b0;
      case (md)
         2'd1:    return c == lim;
         2'd2:    return c == 8'd0;
         default: return c == 8'hFF;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues what the outputs must show.
   task automatic step(input logic r, input logic e, input logic [1:0] md,
                       input logic [7:0] lim, input string req);
      exp_t x;
      @(negedge clk);
      rst = r; en = e; mode = md; limit = lim;
      x.tk = mtick(r, e, md, lim, m_cnt);
      x.cn = m_cnt;
      x.req = req;
      sb.push_back(x);
      if (r)      m_cnt = (md == 2'd2) ? lim : 8'd0;
      else if (e) m_cnt = mnext(md, lim, m_cnt);
   endtask

   task automatic segment(input int period, input string req);
      exp_period = period;
      sp_req = req;
      have_prev = 1'b0;
   endtask

   // Monitor: pops the scoreboard and checks tick spacing.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() != 0) begin
            exp_t x;
            x = sb.pop_front();
            check(tick === x.tk, x.req, "tick", int'(tick), int'(x.tk));
            check(count === x.cn, x.req, "count", int'(count), int'(x.cn));
         end
         if (tick === 1'b1) begin
            if (exp_period > 0 && have_prev)
               check(en_idx - prev_idx == exp_period, sp_req, "tick spacing",
                     en_idx - prev_idx, exp_period);
            prev_idx = en_idx;
            have_prev = 1'b1;
         end
         if (en === 1'b1 && rst === 1'b0) en_idx++;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      segment(0, "R7");
      @(posedge clk);
      @(posedge clk);
      m_cnt = 8'd0;
      // R7: reset state in free-run mode
      for (int i = 0; i < 3; i++) step(1, 1, 2'd0, 8'd0, "R7");
      // R1 R2: free-run divide by 256 over three periods
      segment(256, "R2");
      for (int i = 0; i < 256 * 3 + 4; i++) step(0, 1, 2'd0, 8'd0, "R1");
      // R6: enable toggling, hold and no tick
      segment(0, "R6");
      for (int i = 0; i < 60; i++) step(0, (i % 3) == 0, 2'd0, 8'd0, "R6");
      // R1: spare code 3 behaves as free-run across the wrap
      for (int i = 0; i < 300; i++) step(0, 1, 2'd3, 8'd0, "R1");
      // R4: switch to modulo with count above limit
      step(1, 0, 2'd0, 8'd0, "R7");
      for (int i = 0; i < 100; i++) step(0, 1, 2'd0, 8'd0, "R1");
      step(0, 0, 2'd1, 8'd20, "R4");
      step(0, 1, 2'd1, 8'd20, "R4");
      step(0, 1, 2'd1, 8'd20, "R4");
      // R3: modulo 60
      step(1, 1, 2'd1, 8'd59, "R7");
      segment(60, "R3");
      for (int i = 0; i < 60 * 3 + 2; i++) step(0, 1, 2'd1, 8'd59, "R3");
      // R7: reset in the middle of a modulo run
      segment(0, "R7");
      step(1, 1, 2'd1, 8'd59, "R7");
      step(0, 1, 2'd1, 8'd59, "R7");
      // R5: reload mode, divide by 9; reset loads the limit
      step(1, 1, 2'd2, 8'd8, "R7");
      segment(9, "R5");
      for (int i = 0; i < 9 * 4 + 2; i++) step(0, 1, 2'd2, 8'd8, "R5");
      // R6 in reload mode
      segment(0, "R6");
      for (int i = 0; i < 20; i++) step(0, (i % 2) == 0, 2'd2, 8'd8, "R6");
      // R8: limit zero in modulo and reload modes
      step(1, 0, 2'd1, 8'd0, "R7");
      segment(1, "R8");
      for (int i = 0; i < 10; i++) step(0, 1, 2'd1, 8'd0, "R8");
      step(1, 0, 2'd2, 8'd0, "R7");
      segment(1, "R8");
      for (int i = 0; i < 10; i++) step(0, 1, 2'd2, 8'd0, "R8");
      @(negedge clk);
      @(negedge clk);
      #2;
      finish_run();
   end
endmodule